// File: doc/BRIEF.md
# Queue-Full Clock-Enable Controller with Incrementing Actor

This block stops a small processing stage, the actor, whenever the queue that receives the actor's results cannot take more data. A Moore state machine watches two flags from that output queue. One flag is high when the queue is completely occupied. The other is high when exactly one free slot remains. The machine decodes a run/stop level from its state, and a flip-flop registers that level before it reaches the actor. The actor therefore sees a glitch-free enable that arrives one cycle late. On an FPGA the enable acts as a clock-enable on the actor's registers and on the read strobe of the input queue, so the clock net itself is never gated.

The actor takes words from a show-ahead input queue, adds one to each word and presents the result to the output queue with a one-cycle write strobe. The parameter `MODEL` selects between two variants of the state machine. The five-state variant passes through a separate recovery state after a full condition. The four-state variant leaves the stopped state directly for the near-full state or the running state. The two variants share every other transition.

The state is visible on a 3-bit port using these codes: 0 = reset, 1 = running, 2 = near full, 3 = stopped, 4 = recovering. Code 4 exists only in the five-state variant.

Top module: `qgate_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0 and `act_en` becomes 0 at that edge. `oq_wr` becomes 0 at the same edge.
- R2: At the first edge after reset is released, the state moves from 0 to 1 and `act_en` becomes 1.
- R3: In state 1, a sampled `oq_afull`=1 with `oq_full`=0 moves the state to 2, and the enable stays high. In state 2, both flags sampled low moves the state back to 1.
- R4: From state 1 or state 2, a sampled `oq_full`=1 moves the state to 3. `act_en` is 0 from the edge after the state enters 3, and it stays 0 while the state remains 3.
- R5: With `MODEL`=5, state 3 moves to 4 when `oq_full` is sampled low. From state 4, `oq_full`=1 leads to state 3. From state 4, `oq_afull`=1 alone leads to state 2, and both flags low lead to state 1.
- R6: With `MODEL`=4, state 3 moves to 2 when `oq_full` is low and `oq_afull` is high. State 3 moves to 1 when both flags are low. State code 4 never appears in this variant.
- R7: Any flag combination not listed for a state keeps that state. Examples are both flags low in state 1, `oq_afull` alone in state 2, and `oq_full` high in state 3.
- R8: `act_en` equals the state-decoded enable, delayed by one register. The decoded enable is low only in state 3.
- R9: When `act_en`=1 and `iq_empty`=0, `iq_rd` is 1. At the next edge `oq_wr` becomes 1 and `oq_data` becomes `iq_data`+1 modulo 2^`DATA_W`.
- R10: While `act_en`=0, `iq_rd` is 0. The edge that follows gives `oq_wr`=0 and leaves `oq_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oq_full | input | 1 | Output queue fully occupied |
| oq_afull | input | 1 | Output queue has exactly one free slot |
| iq_empty | input | 1 | Input queue holds no word |
| iq_data | input | DATA_W | Head word of the show-ahead input queue |
| iq_rd | output | 1 | Pop strobe to the input queue |
| oq_wr | output | 1 | Write strobe to the output queue |
| oq_data | output | DATA_W | Incremented word for the output queue |
| act_en | output | 1 | Registered actor enable |
| fsm_state | output | 3 | Current controller state code |

## Verification
Both variants run side by side on the same flags. Each flag pattern therefore shows the transitions the variants share and the ones where they differ. Releasing full while near-full is still set separates the recovery-state path from the direct return to near-full. Releasing both flags at once separates the paths back to running. Re-asserting full from the recovery state checks the re-entry into the stopped state. Data patterns include an ordinary word and the all-ones word, which checks the wrap of the increment. A stall with the input queue non-empty shows the one-cycle enable delay: one more word is written after full is sampled, and then the output holds.

// File: rtl/qgate_pkg.sv
package qgate_pkg;

   localparam int STATE_PORT_W = 3;

   localparam logic [2:0] ST_RESET = 3'd0;
   localparam logic [2:0] ST_RUN   = 3'd1;
   localparam logic [2:0] ST_NEAR  = 3'd2;
   localparam logic [2:0] ST_STOP  = 3'd3;
   localparam logic [2:0] ST_RECOV = 3'd4;

   function automatic int state_bits(input int model);
      return (model == 5) ? 3 : 2;
   endfunction

endpackage

// File: rtl/qgate_fsm.sv
module qgate_fsm
   import qgate_pkg::*;
#(
   parameter int MODEL = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    full_i,
   input  logic                    afull_i,
   output logic                    run_d_o,
   output logic [STATE_PORT_W-1:0] state_o
);

   localparam int SW = state_bits(MODEL);

   logic [SW-1:0] cur_q;
   logic [SW-1:0] nxt;

   always_ff @(posedge clk) begin
      if (rst) cur_q <= SW'(ST_RESET);
      else     cur_q <= nxt;
   end

   generate
      if (MODEL == 5) begin : g_five
         always_comb begin
            nxt = cur_q;
            case (cur_q)
               SW'(ST_RESET): nxt = SW'(ST_RUN);
               SW'(ST_RUN): begin
                  if (full_i)       nxt = SW'(ST_STOP);
                  else if (afull_i) nxt = SW'(ST_NEAR);
               end
               SW'(ST_NEAR): begin
                  if (full_i)        nxt = SW'(ST_STOP);
                  else if (!afull_i) nxt = SW'(ST_RUN);
               end
               SW'(ST_STOP): begin
                  if (!full_i) nxt = SW'(ST_RECOV);
               end
               SW'(ST_RECOV): begin
                  if (full_i)       nxt = SW'(ST_STOP);
                  else if (afull_i) nxt = SW'(ST_NEAR);
                  else              nxt = SW'(ST_RUN);
               end
               default: nxt = SW'(ST_RESET);
            endcase
         end
      end else if (MODEL == 4) begin : g_four
         always_comb begin
            nxt = cur_q;
            case (cur_q)
               SW'(ST_RESET): nxt = SW'(ST_RUN);
               SW'(ST_RUN): begin
                  if (full_i)       nxt = SW'(ST_STOP);
                  else if (afull_i) nxt = SW'(ST_NEAR);
               end
               SW'(ST_NEAR): begin
                  if (full_i)        nxt = SW'(ST_STOP);
                  else if (!afull_i) nxt = SW'(ST_RUN);
               end
               default: begin
                  if (!full_i) nxt = afull_i ? SW'(ST_NEAR) : SW'(ST_RUN);
               end
            endcase
         end
      end else begin : g_bad_model
         $error("qgate_fsm: MODEL must be 4 or 5");
      end
   endgenerate

   assign run_d_o = (cur_q != SW'(ST_STOP));
   assign state_o = STATE_PORT_W'(cur_q);

endmodule

// File: rtl/qgate_enreg.sv
module qgate_enreg #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   always_ff @(posedge clk) begin
      if (rst) q_o <= RST_VAL;
      else     q_o <= d_i;
   end

endmodule

// File: rtl/qgate_actor.sv
module qgate_actor #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic              src_empty_i,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              src_rd_o,
   output logic              dst_wr_o,
   output logic [DATA_W-1:0] dst_data_o
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

   logic take;

   assign take     = en_i & ~src_empty_i;
   assign src_rd_o = take;

   always_ff @(posedge clk) begin
      if (rst) begin
         dst_wr_o   <= 1'b0;
         dst_data_o <= '0;
      end else if (en_i) begin
         dst_wr_o <= take;
         if (take) dst_data_o <= src_data_i + STEP;
      end else begin
         dst_wr_o <= 1'b0;
      end
   end

endmodule

// File: rtl/qgate_top.sv
module qgate_top
   import qgate_pkg::*;
#(
   parameter int MODEL  = 5,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    oq_full,
   input  logic                    oq_afull,
   input  logic                    iq_empty,
   input  logic [DATA_W-1:0]       iq_data,
   output logic                    iq_rd,
   output logic                    oq_wr,
   output logic [DATA_W-1:0]       oq_data,
   output logic                    act_en,
   output logic [STATE_PORT_W-1:0] fsm_state
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("qgate_top: DATA_W must be at least 1");
      end
   endgenerate

   logic run_d;

   qgate_fsm #(.MODEL(MODEL)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .full_i  (oq_full),
      .afull_i (oq_afull),
      .run_d_o (run_d),
      .state_o (fsm_state)
   );

   qgate_enreg #(.RST_VAL(1'b0)) u_enreg (
      .clk (clk),
      .rst (rst),
      .d_i (run_d),
      .q_o (act_en)
   );

   qgate_actor #(.DATA_W(DATA_W)) u_actor (
      .clk         (clk),
      .rst         (rst),
      .en_i        (act_en),
      .src_empty_i (iq_empty),
      .src_data_i  (iq_data),
      .src_rd_o    (iq_rd),
      .dst_wr_o    (oq_wr),
      .dst_data_o  (oq_data)
   );

endmodule

// File: rtl/qgate_chk.sv
module qgate_chk #(
   parameter int MODEL  = 5,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              oq_full,
   input logic              oq_afull,
   input logic              iq_empty,
   input logic [DATA_W-1:0] iq_data,
   input logic              iq_rd,
   input logic              oq_wr,
   input logic [DATA_W-1:0] oq_data,
   input logic              act_en,
   input logic [2:0]        fsm_state
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (fsm_state == 3'd0 && !act_en && !oq_wr));

   assert_stop_en_R4: assert property (@(posedge clk) disable iff (rst)
      (fsm_state == 3'd3) |=> !act_en);

   assert_run_en_R8: assert property (@(posedge clk) disable iff (rst)
      (fsm_state != 3'd3) |=> act_en);

   assert_full_stop_R4: assert property (@(posedge clk) disable iff (rst)
      ((fsm_state == 3'd1 || fsm_state == 3'd2) && oq_full) |=> (fsm_state == 3'd3));

   assert_near_R3: assert property (@(posedge clk) disable iff (rst)
      (fsm_state == 3'd1 && oq_afull && !oq_full) |=> (fsm_state == 3'd2));

   assert_incr_R9: assert property (@(posedge clk) disable iff (rst)
      iq_rd |=> (oq_wr && oq_data == $past(iq_data) + ONE));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !act_en |=> (!oq_wr && oq_data == $past(oq_data)));

   assert_nord_R10: assert property (@(posedge clk) disable iff (rst)
      !act_en |-> !iq_rd);

   generate
      if (MODEL == 4) begin : g_four_chk
         assert_no_recov_R6: assert property (@(posedge clk) disable iff (rst)
            fsm_state != 3'd4);
      end else begin : g_five_chk
         assert_recov_R5: assert property (@(posedge clk) disable iff (rst)
            (fsm_state == 3'd3 && !oq_full) |=> (fsm_state == 3'd4));
      end
   endgenerate

   wire unused_ok = &{1'b0, iq_empty};

endmodule

bind qgate_top qgate_chk #(.MODEL(MODEL), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .oq_full   (oq_full),
   .oq_afull  (oq_afull),
   .iq_empty  (iq_empty),
   .iq_data   (iq_data),
   .iq_rd     (iq_rd),
   .oq_wr     (oq_wr),
   .oq_data   (oq_data),
   .act_en    (act_en),
   .fsm_state (fsm_state)
);

// File: tb/sim_qgate_top.sv
`timescale 1ns/1ps
module sim_qgate_top;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          full = 1'b0;
   logic          afull = 1'b0;
   logic          empty = 1'b1;
   logic [DW-1:0] din = '0;

   logic          rd5, wr5, en5;
   logic [DW-1:0] dout5;
   logic [2:0]    st5;
   logic          rd4, wr4, en4;
   logic [DW-1:0] dout4;
   logic [2:0]    st4;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   qgate_top #(.MODEL(5), .DATA_W(DW)) u0 (
      .clk(clk), .rst(rst), .oq_full(full), .oq_afull(afull),
      .iq_empty(empty), .iq_data(din), .iq_rd(rd5), .oq_wr(wr5),
      .oq_data(dout5), .act_en(en5), .fsm_state(st5)
   );

   qgate_top #(.MODEL(4), .DATA_W(DW)) u1 (
      .clk(clk), .rst(rst), .oq_full(full), .oq_afull(afull),
      .iq_empty(empty), .iq_data(din), .iq_rd(rd4), .oq_wr(wr4),
      .oq_data(dout4), .act_en(en4), .fsm_state(st4)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(3);
      chk("R1 five state", st5, 0);
      chk("R1 four state", st4, 0);
      chk("R1 en", en5, 0);
      chk("R1 en four", en4, 0);
      chk("R1 wr", wr5, 0);
   endtask

   task automatic t_start();
      rst = 1'b0;
      step(1);
      chk("R2 five state", st5, 1);
      chk("R2 four state", st4, 1);
      chk("R2 en", en5, 1);
      chk("R2 en four", en4, 1);
   endtask

   task automatic t_near();
      afull = 1'b1;
      step(1);
      chk("R3 five to near", st5, 2);
      chk("R3 four to near", st4, 2);
      chk("R3 en kept", en5, 1);
      step(1);
      chk("R7 near holds on afull", st5, 2);
      afull = 1'b0;
      step(1);
      chk("R3 near back to run", st5, 1);
      chk("R3 four near back to run", st4, 1);
      step(1);
      chk("R7 run holds on no flags", st5, 1);
   endtask

   task automatic t_full();
      afull = 1'b1;
      full  = 1'b1;
      step(1);
      chk("R4 five to stop", st5, 3);
      chk("R4 four to stop", st4, 3);
      chk("R8 en still high one cycle", en5, 1);
      step(1);
      chk("R7 stop holds on full", st5, 3);
      chk("R4 en low five", en5, 0);
      chk("R4 en low four", en4, 0);
   endtask

   task automatic t_recover();
      full = 1'b0;
      step(1);
      chk("R5 stop to recover", st5, 4);
      chk("R6 stop to near", st4, 2);
      chk("R8 en lags state five", en5, 0);
      chk("R8 en lags state four", en4, 0);
      step(1);
      chk("R5 recover to near", st5, 2);
      chk("R8 en back five", en5, 1);
      chk("R8 en back four", en4, 1);
      full = 1'b1;
      step(1);
      full  = 1'b0;
      afull = 1'b0;
      step(1);
      chk("R5 stop to recover clear", st5, 4);
      chk("R6 stop to run", st4, 1);
      step(1);
      chk("R5 recover to run", st5, 1);
      afull = 1'b1;
      full  = 1'b1;
      step(1);
      full = 1'b0;
      step(1);
      chk("R5 recover again", st5, 4);
      full = 1'b1;
      step(1);
      chk("R5 recover to stop", st5, 3);
      full  = 1'b0;
      afull = 1'b0;
      step(2);
      chk("R5 final run", st5, 1);
      chk("R6 final run", st4, 1);
      step(1);
      chk("R8 en restored", en5, 1);
   endtask

   task automatic t_data();
      empty = 1'b0;
      din   = 8'h12;
      #0;
      chk("R9 read strobe", rd5, 1);
      step(1);
      chk("R9 write strobe", wr5, 1);
      chk("R9 incremented", dout5, 8'h13);
      chk("R9 incremented four", dout4, 8'h13);
      din = 8'hFF;
      step(1);
      chk("R9 wrap", dout5, 8'h00);
      chk("R9 wrap write", wr5, 1);
      empty = 1'b1;
      step(1);
      chk("R9 no write when empty", wr5, 0);
      chk("R9 data kept when empty", dout5, 8'h00);
   endtask

   task automatic t_stall();
      empty = 1'b0;
      din   = 8'h40;
      afull = 1'b1;
      full  = 1'b1;
      step(1);
      chk("R8 word taken before enable drops", dout5, 8'h41);
      chk("R8 write before enable drops", wr5, 1);
      step(1);
      chk("R10 enable low", en5, 0);
      chk("R10 no read five", rd5, 0);
      chk("R10 no read four", rd4, 0);
      din = 8'h77;
      step(1);
      chk("R10 no write", wr5, 0);
      chk("R10 data held", dout5, 8'h41);
      chk("R10 data held four", dout4, 8'h41);
      step(1);
      chk("R10 still held", dout5, 8'h41);
      chk("R10 still no write four", wr4, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_start();
      t_near();
      t_full();
      t_recover();
      t_data();
      t_stall();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule